// File: doc/BRIEF.md
# Memory Protection Region Checker

This block decides, for every memory access presented to it, whether the access may proceed or must be refused. Eight programmable protection regions are compared in parallel against the access address. Each region carries a base, a power-of-two size, an enable, a mask that removes individual eighths of the region, a 3-bit permission code and an execute-never bit. When several regions cover the address, the highest-numbered one decides. When no region covers it, a background region applies that admits only privileged accesses.

The access is described by an address, a write flag, a privileged flag and an instruction-fetch flag, qualified by a valid strobe. One cycle after the strobe the block returns a response pulse. That pulse carries a fault flag, a 2-bit cause and the number of the region that matched. Instruction fetches and data accesses use the same region settings. A global enable switches checking off, and every access is then admitted.

Top module: `mem_prot_checker`

## Requirements
- R1: Exactly one cycle after a cycle with `req_valid_i` high, `resp_valid_o` is high together with that access's `fault_o`, `cause_o`, `rgn_hit_o` and `rgn_id_o`. In a cycle after one without a request, `resp_valid_o`, `fault_o`, `cause_o`, `rgn_hit_o` and `rgn_id_o` are all zero.
- R2: A region with size code N covers 2^(N+1) bytes, and codes below 4 are treated as 4. Base address bits below the region size are ignored, so the region starts at the base rounded down to its size.
- R3: When several enabled regions cover the address, the highest-numbered one supplies the permission, execute-never and the reported region number.
- R4: For effective size code 7 or more, bit i of the 8-bit disable mask removes eighth i of the region from the match, with bit 0 the lowest-addressed eighth. Lower regions or the background then apply there. For effective codes 4 to 6 the mask is ignored.
- R5: If no enabled region covers the address, a privileged access is admitted and an unprivileged access faults with cause 01. `rgn_hit_o` is 0 and `rgn_id_o` is 0 in both cases.
- R6: Permission codes: 000 none; 001 privileged read/write only; 010 privileged read/write, unprivileged read; 011 read/write for all; 100 none; 101 privileged read only; 110 and 111 read for all. A disallowed access faults with cause 10.
- R7: An instruction fetch from a matched region with execute-never set faults with cause 11, whatever the permission code. Any other fetch is checked as a read.
- R8: With `chk_en_i` low, every access is admitted with `fault_o`=0, cause 00 and `rgn_hit_o`=0.
- R9: During and right after reset, all outputs are zero.
- R10: On an admitted or faulting access that matched a region, `rgn_hit_o` is 1 and `rgn_id_o` gives that region's number. Cause 00 always goes with `fault_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chk_en_i | input | 1 | Global checking enable |
| req_valid_i | input | 1 | Access strobe |
| req_addr_i | input | 32 | Access address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_priv_i | input | 1 | 1 = privileged access |
| req_fetch_i | input | 1 | 1 = instruction fetch |
| rgn_base_i | input | 256 | Region bases, region i in bits [32i+31:32i] |
| rgn_size_i | input | 40 | Region size codes, 5 bits each |
| rgn_en_i | input | 8 | Region enables |
| rgn_srd_i | input | 64 | Subregion disable masks, 8 bits each |
| rgn_ap_i | input | 24 | Permission codes, 3 bits each |
| rgn_xn_i | input | 8 | Execute-never bits |
| resp_valid_o | output | 1 | Response pulse |
| fault_o | output | 1 | Access refused |
| cause_o | output | 2 | 00 none, 01 no match, 10 permission, 11 execute-never |
| rgn_hit_o | output | 1 | A programmed region matched |
| rgn_id_o | output | 3 | Matched region number |

## Verification
The assertions assume that the region configuration inputs stay stable between a request and its response. They also assume that the flags of a request are known whenever `req_valid_i` is high. The bench changes region settings only while no request is outstanding and drives every request field in the same cycle as the strobe. Random sizes run from code 3 to 20, so small regions, regions with and without subregions, and the treatment of codes below the minimum are all exercised. Addresses are drawn near the programmed bases so that overlaps, disabled eighths and region edges are hit often.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  localparam int SIZE_W          = 5;
  localparam int SRD_W           = 8;
  localparam int AP_W            = 3;
  localparam int MIN_SIZE_CODE   = 4;
  localparam int SUB_MIN_CODE    = 7;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_NOMATCH = 2'd1,
    CAUSE_PERM    = 2'd2,
    CAUSE_XN      = 2'd3
  } cause_e;
endpackage

// File: rtl/mpc_region_match.sv
module mpc_region_match
  import mpc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              en_i,
  input  logic [SRD_W-1:0]  srd_i,
  output logic              hit_o
);
  logic [SIZE_W-1:0] n_eff;
  logic [ADDR_W-1:0] keep_mask;
  logic [ADDR_W-1:0] shifted;
  logic [2:0]        sub_idx;
  logic              in_range;
  logic              sub_on;

  always_comb begin
    n_eff = (size_i < SIZE_W'(MIN_SIZE_CODE)) ? SIZE_W'(MIN_SIZE_CODE) : size_i;
    for (int b = 0; b < ADDR_W; b++) keep_mask[b] = (b > int'(n_eff));
    in_range = (((addr_i ^ base_i) & keep_mask) == '0);
    // eighth index sits just below the region size bit
    shifted  = addr_i >> (n_eff - SIZE_W'(2));
    sub_idx  = shifted[2:0];
    sub_on   = (n_eff >= SIZE_W'(SUB_MIN_CODE));
    hit_o    = en_i & in_range & ~(sub_on & srd_i[sub_idx]);
  end
endmodule

// File: rtl/mpc_prio_sel.sv
module mpc_prio_sel #(
  parameter int NUM_RGN = 8,
  localparam int ID_W   = $clog2(NUM_RGN)
) (
  input  logic [NUM_RGN-1:0] hit_vec_i,
  output logic               any_hit_o,
  output logic [ID_W-1:0]    sel_id_o
);
  always_comb begin
    any_hit_o = |hit_vec_i;
    sel_id_o  = '0;
    for (int i = 0; i < NUM_RGN; i++)
      if (hit_vec_i[i]) sel_id_o = ID_W'(i);
  end

  // selected region hits and nothing above it does
  always_comb begin
    assert_prio_R3: assert (!any_hit_o ||
      ((hit_vec_i >> sel_id_o) == {{(NUM_RGN-1){1'b0}}, 1'b1}));
  end
endmodule

// File: rtl/mpc_perm_check.sv
module mpc_perm_check
  import mpc_pkg::*;
(
  input  logic [AP_W-1:0] ap_i,
  input  logic            priv_i,
  input  logic            write_i,
  output logic            ok_o
);
  logic priv_rd, priv_wr, user_rd, user_wr;

  always_comb begin
    priv_rd = 1'b0; priv_wr = 1'b0; user_rd = 1'b0; user_wr = 1'b0;
    unique case (ap_i)
      3'b001: begin priv_rd = 1'b1; priv_wr = 1'b1; end
      3'b010: begin priv_rd = 1'b1; priv_wr = 1'b1; user_rd = 1'b1; end
      3'b011: begin priv_rd = 1'b1; priv_wr = 1'b1; user_rd = 1'b1; user_wr = 1'b1; end
      3'b101: priv_rd = 1'b1;
      3'b110,
      3'b111: begin priv_rd = 1'b1; user_rd = 1'b1; end
      default: ; // 000 and reserved 100: no access
    endcase
    if (priv_i) ok_o = write_i ? priv_wr : priv_rd;
    else        ok_o = write_i ? user_wr : user_rd;
  end
endmodule

// File: rtl/mem_prot_checker.sv
module mem_prot_checker
  import mpc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_RGN = 8,
  localparam int ID_W   = $clog2(NUM_RGN)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      chk_en_i,
  input  logic                      req_valid_i,
  input  logic [ADDR_W-1:0]         req_addr_i,
  input  logic                      req_write_i,
  input  logic                      req_priv_i,
  input  logic                      req_fetch_i,
  input  logic [NUM_RGN*ADDR_W-1:0] rgn_base_i,
  input  logic [NUM_RGN*SIZE_W-1:0] rgn_size_i,
  input  logic [NUM_RGN-1:0]        rgn_en_i,
  input  logic [NUM_RGN*SRD_W-1:0]  rgn_srd_i,
  input  logic [NUM_RGN*AP_W-1:0]   rgn_ap_i,
  input  logic [NUM_RGN-1:0]        rgn_xn_i,
  output logic                      resp_valid_o,
  output logic                      fault_o,
  output logic [1:0]                cause_o,
  output logic                      rgn_hit_o,
  output logic [ID_W-1:0]           rgn_id_o
);
  logic [NUM_RGN-1:0] hit_vec;
  logic               any_hit;
  logic [ID_W-1:0]    sel_id;
  logic [AP_W-1:0]    sel_ap;
  logic               sel_xn;
  logic               perm_ok;
  logic               rd_write;
  cause_e             cause_d;

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
    mpc_region_match #(.ADDR_W(ADDR_W)) u_match (
      .addr_i (req_addr_i),
      .base_i (rgn_base_i[g*ADDR_W +: ADDR_W]),
      .size_i (rgn_size_i[g*SIZE_W +: SIZE_W]),
      .en_i   (rgn_en_i[g]),
      .srd_i  (rgn_srd_i[g*SRD_W +: SRD_W]),
      .hit_o  (hit_vec[g])
    );
  end

  mpc_prio_sel #(.NUM_RGN(NUM_RGN)) u_prio (
    .hit_vec_i (hit_vec),
    .any_hit_o (any_hit),
    .sel_id_o  (sel_id)
  );

  assign sel_ap   = rgn_ap_i[sel_id*AP_W +: AP_W];
  assign sel_xn   = rgn_xn_i[sel_id];
  assign rd_write = req_write_i & ~req_fetch_i;

  mpc_perm_check u_perm (
    .ap_i    (sel_ap),
    .priv_i  (req_priv_i),
    .write_i (rd_write),
    .ok_o    (perm_ok)
  );

  always_comb begin
    cause_d = CAUSE_NONE;
    if (chk_en_i) begin
      if (!any_hit)                 cause_d = req_priv_i ? CAUSE_NONE : CAUSE_NOMATCH;
      else if (req_fetch_i && sel_xn) cause_d = CAUSE_XN;
      else if (!perm_ok)            cause_d = CAUSE_PERM;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      fault_o      <= 1'b0;
      cause_o      <= 2'b00;
      rgn_hit_o    <= 1'b0;
      rgn_id_o     <= '0;
    end else begin
      resp_valid_o <= req_valid_i;
      fault_o      <= req_valid_i && (cause_d != CAUSE_NONE);
      cause_o      <= req_valid_i ? cause_d : CAUSE_NONE;
      rgn_hit_o    <= req_valid_i && chk_en_i && any_hit;
      rgn_id_o     <= (req_valid_i && chk_en_i && any_hit) ? sel_id : '0;
    end
  end

  assert_resp_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);
  assert_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!resp_valid_o && !fault_o && cause_o == 2'b00 && !rgn_hit_o));
  assert_bg_priv_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && chk_en_i && req_priv_i && !any_hit) |=> (!fault_o && !rgn_hit_o));
  assert_bg_user_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && chk_en_i && !req_priv_i && !any_hit) |=> (fault_o && cause_o == CAUSE_NOMATCH));
  assert_xn_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && chk_en_i && req_fetch_i && any_hit && sel_xn) |=> (fault_o && cause_o == CAUSE_XN));
  assert_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !chk_en_i) |=> (resp_valid_o && !fault_o && !rgn_hit_o));
  assert_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> (fault_o == (cause_o != 2'b00)));
endmodule

// File: tb/tb_mem_prot_checker.sv
module tb_mem_prot_checker;
  localparam int NR = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic chk_en_i = 1'b0;
  logic req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic req_write_i = 1'b0, req_priv_i = 1'b0, req_fetch_i = 1'b0;
  logic [NR*32-1:0] rgn_base_i;
  logic [NR*5-1:0]  rgn_size_i;
  logic [NR-1:0]    rgn_en_i;
  logic [NR*8-1:0]  rgn_srd_i;
  logic [NR*3-1:0]  rgn_ap_i;
  logic [NR-1:0]    rgn_xn_i;
  logic resp_valid_o, fault_o, rgn_hit_o;
  logic [1:0] cause_o;
  logic [2:0] rgn_id_o;

  logic [31:0] t_base [NR];
  logic [4:0]  t_size [NR];
  logic        t_en   [NR];
  logic [7:0]  t_srd  [NR];
  logic [2:0]  t_ap   [NR];
  logic        t_xn   [NR];

  int errors = 0;
  int checks = 0;

  always #4 clk_i = ~clk_i;

  always_comb begin
    for (int i = 0; i < NR; i++) begin
      rgn_base_i[i*32 +: 32] = t_base[i];
      rgn_size_i[i*5 +: 5]   = t_size[i];
      rgn_en_i[i]            = t_en[i];
      rgn_srd_i[i*8 +: 8]    = t_srd[i];
      rgn_ap_i[i*3 +: 3]     = t_ap[i];
      rgn_xn_i[i]            = t_xn[i];
    end
  end

  mem_prot_checker dut (.*);

  function automatic logic allowed(logic [2:0] ap, logic p, logic w);
    logic pr, pw, ur, uw;
    pr = (ap == 3'd1) || (ap == 3'd2) || (ap == 3'd3) || (ap == 3'd5) || (ap >= 3'd6);
    pw = (ap == 3'd1) || (ap == 3'd2) || (ap == 3'd3);
    ur = (ap == 3'd2) || (ap == 3'd3) || (ap >= 3'd6);
    uw = (ap == 3'd3);
    return p ? (w ? pw : pr) : (w ? uw : ur);
  endfunction

  // returns {fault, cause[1:0], hit, id[2:0]}
  function automatic logic [6:0] model(logic [31:0] a, logic w, logic p, logic f);
    logic hit = 1'b0;
    logic [2:0] id = '0;
    logic [1:0] c;
    if (!chk_en_i) return 7'd0;
    for (int i = 0; i < NR; i++) begin
      int n;
      longint unsigned sz, ab, a64, off, sub;
      if (!t_en[i]) continue;
      n   = (t_size[i] < 5'd4) ? 4 : int'(t_size[i]);
      sz  = 64'd1 << (n + 1);
      ab  = {32'd0, t_base[i]} & ~(sz - 64'd1);
      a64 = {32'd0, a};
      if (a64 < ab || a64 >= ab + sz) continue;
      off = a64 - ab;
      sub = off / (sz >> 3);
      if (n >= 7 && t_srd[i][sub[2:0]]) continue;
      hit = 1'b1;
      id  = 3'(i);
    end
    if (!hit)                   c = p ? 2'd0 : 2'd1;
    else if (f && t_xn[id])     c = 2'd3;
    else if (!allowed(t_ap[id], p, w && !f)) c = 2'd2;
    else                        c = 2'd0;
    return {c != 2'd0, c, hit, id};
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got valid/fault/cause/hit/id=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic w, input logic p, input logic f,
                        input string tag);
    logic [6:0] e;
    @(negedge clk_i);
    req_addr_i = a; req_write_i = w; req_priv_i = p; req_fetch_i = f;
    req_valid_i = 1'b1;
    e = model(a, w, p, f);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(tag, {resp_valid_o, fault_o, cause_o, rgn_hit_o, rgn_id_o}, {1'b1, e});
  endtask

  task automatic clear_rgns();
    for (int i = 0; i < NR; i++) begin
      t_base[i] = '0; t_size[i] = 5'd4; t_en[i] = 1'b0;
      t_srd[i] = '0; t_ap[i] = 3'd0; t_xn[i] = 1'b0;
    end
  endtask

  task automatic set_rgn(input int i, input logic [31:0] b, input logic [4:0] s,
                         input logic [7:0] srd, input logic [2:0] ap, input logic xn);
    t_base[i] = b; t_size[i] = s; t_en[i] = 1'b1; t_srd[i] = srd; t_ap[i] = ap; t_xn[i] = xn;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_rgns();
    repeat (3) @(negedge clk_i);
    check("R9 reset", {resp_valid_o, fault_o, cause_o, rgn_hit_o, rgn_id_o}, 8'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9 after reset", {resp_valid_o, fault_o, cause_o, rgn_hit_o, rgn_id_o}, 8'd0);

    // R8: checker off admits an unprivileged access with nothing programmed
    chk_en_i = 1'b0;
    access(32'h0000_4000, 1'b1, 1'b0, 1'b0, "R8 disabled");
    chk_en_i = 1'b1;
    access(32'h0000_4000, 1'b1, 1'b0, 1'b0, "R5 unpriv background");
    access(32'h0000_4000, 1'b1, 1'b1, 1'b0, "R5 priv background");
    @(negedge clk_i);
    check("R1 idle after response", {resp_valid_o, fault_o, cause_o, rgn_hit_o, rgn_id_o}, 8'd0);

    // R2: minimum size and size codes below the minimum
    set_rgn(0, 32'h0000_1000, 5'd4, 8'h00, 3'd3, 1'b0);
    access(32'h0000_101F, 1'b1, 1'b0, 1'b0, "R2 last byte of 32B");
    access(32'h0000_1020, 1'b1, 1'b0, 1'b0, "R2 past 32B");
    t_size[0] = 5'd1;
    access(32'h0000_101C, 1'b0, 1'b0, 1'b0, "R2 code below minimum");
    access(32'h0000_1020, 1'b0, 1'b0, 1'b0, "R2 code below minimum edge");
    set_rgn(0, 32'h0000_1010, 5'd4, 8'h00, 3'd3, 1'b0);
    access(32'h0000_1005, 1'b0, 1'b0, 1'b0, "R2 unaligned base rounded");

    // R4/R3: eighths disabled in a large overlapping region
    clear_rgns();
    set_rgn(1, 32'h2000_0000, 5'd16, 8'h00, 3'd3, 1'b0);
    set_rgn(2, 32'h2000_0000, 5'd18, 8'h03, 3'd6, 1'b0);
    access(32'h2000_0010, 1'b1, 1'b0, 1'b0, "R4 disabled eighth shows lower region");
    access(32'h2003_0000, 1'b1, 1'b0, 1'b0, "R4 enabled eighth RO");
    access(32'h2001_0000, 1'b0, 1'b0, 1'b0, "R3 lower region through hole");
    t_en[1] = 1'b0;
    t_srd[2] = 8'h80;
    access(32'h2007_FFF0, 1'b0, 1'b0, 1'b0, "R4 top eighth off unpriv");
    access(32'h2007_FFF0, 1'b0, 1'b1, 1'b0, "R4 top eighth off priv");
    access(32'h2006_FFF0, 1'b0, 1'b0, 1'b0, "R4 seventh eighth on");
    clear_rgns();
    set_rgn(4, 32'h0000_8000, 5'd6, 8'hFF, 3'd3, 1'b0);
    access(32'h0000_8010, 1'b1, 1'b0, 1'b0, "R4 mask ignored at 128B");

    // R3: overlap priority
    clear_rgns();
    set_rgn(3, 32'h1000_0000, 5'd15, 8'h00, 3'd3, 1'b0);
    set_rgn(5, 32'h1000_0000, 5'd12, 8'h00, 3'd6, 1'b0);
    access(32'h1000_0100, 1'b1, 1'b0, 1'b0, "R3 higher region wins");
    access(32'h1000_4000, 1'b1, 1'b0, 1'b0, "R10 only lower region");

    // R6: full permission sweep
    clear_rgns();
    for (int ap = 0; ap < 8; ap++) begin
      set_rgn(6, 32'h4000_0000, 5'd10, 8'h00, 3'(ap), 1'b0);
      for (int k = 0; k < 4; k++)
        access(32'h4000_0040, k[0], k[1], 1'b0, "R6 permission sweep");
    end

    // R7: execute-never and fetch-as-read
    set_rgn(6, 32'h4000_0000, 5'd10, 8'h00, 3'd3, 1'b1);
    access(32'h4000_0040, 1'b0, 1'b1, 1'b1, "R7 XN fetch");
    access(32'h4000_0040, 1'b0, 1'b1, 1'b0, "R7 XN data read ok");
    set_rgn(6, 32'h4000_0000, 5'd10, 8'h00, 3'd5, 1'b0);
    access(32'h4000_0040, 1'b1, 1'b1, 1'b1, "R7 fetch checked as read");
    set_rgn(6, 32'h4000_0000, 5'd10, 8'h00, 3'd1, 1'b0);
    access(32'h4000_0040, 1'b0, 1'b0, 1'b1, "R7 unpriv fetch perm");
    chk_en_i = 1'b0;
    access(32'h4000_0040, 1'b0, 1'b0, 1'b1, "R8 disabled over region");
    chk_en_i = 1'b1;

    // random mix
    for (int it = 0; it < 600; it++) begin
      if (it % 20 == 0) begin
        for (int i = 0; i < NR; i++) begin
          logic [4:0] s;
          s = 5'($urandom_range(3, 20));
          t_base[i] = 32'h3000_0000 | ($urandom & 32'h001F_FFE0);
          t_size[i] = s;
          t_en[i]   = ($urandom_range(0, 4) != 0);
          t_srd[i]  = ($urandom_range(0, 1) != 0) ? 8'($urandom) : 8'h00;
          t_ap[i]   = 3'($urandom);
          t_xn[i]   = ($urandom_range(0, 3) == 0);
        end
      end
      begin
        int k;
        logic [31:0] a;
        k = $urandom_range(0, NR - 1);
        a = (t_base[k] & ~((32'd1 << (int'(t_size[k]) + 1)) - 1))
            + ($urandom & ((32'd1 << (int'(t_size[k]) + 2)) - 1));
        access(a, 1'($urandom), 1'($urandom), 1'($urandom), "R2 R3 R4 R6 R7 random");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule